// File: doc/BRIEF.md
# Cartridge Bank Controller with Nine-Bit ROM Page Register

This block sits between a CPU with a 16-bit address bus and a cartridge's ROM and battery RAM. It watches CPU writes into the ROM part of the address map and treats them as register writes. One range loads the low eight bits of a nine-bit ROM page number, a second range loads its ninth bit, a third loads a four-bit RAM page number, and a fourth arms or disarms RAM access. From these registers and the current CPU address it forms the physical ROM and RAM addresses. The memory arrays themselves are outside the block.

The lower 16 KiB of the CPU map always shows the first ROM page. The next 16 KiB shows the selected page, and page 0 may be selected there with no substitution. The 8 KiB RAM window shows the selected RAM page. The integrator gives the ROM and RAM page counts as inputs. Reads that would fall past the fitted memory, or into RAM that is disarmed or absent, raise a flag that tells the data path to return zero. RAM writes under the same conditions are dropped and not wrapped.

Top module: `rom9_bank_ctrl`

## Requirements
- R1: After reset the ROM page register holds 1, the RAM page register holds 0 and RAM access is disarmed.
- R2: A write to 0x2000–0x2FFF copies all eight data bits into ROM page bits 7:0 and keeps bit 8.
- R3: A write to 0x3000–0x3FFF copies data bit 0 into ROM page bit 8, ignores data bits 7:1 and keeps bits 7:0.
- R4: Writing 0 to both ROM page fields selects page 0, so a read of 0x4000 gives ROM address 0, with no remap to page 1.
- R5: A read of 0x0000–0x3FFF gives a ROM address equal to the CPU address, and zero_data stays low.
- R6: A read of 0x4000–0x7FFF gives ROM address page×0x4000 + (address − 0x4000). zero_data is high exactly when the page is at or above rom_bank_count. zero_data is never high without cpu_rd.
- R7: A write to 0x0000–0x1FFF arms RAM access when the data byte is 0x0A and disarms it for any other value.
- R8: A write to 0x4000–0x5FFF loads the RAM page from data bits 3:0 when ram_bank_count is nonzero. When ram_bank_count is zero the write is ignored.
- R9: In 0xA000–0xBFFF, ram_addr is RAM page×0x2000 + (address − 0xA000). A read there raises zero_data when RAM is disarmed or the RAM page is at or above ram_bank_count.
- R10: ram_we is high only for a write in 0xA000–0xBFFF while RAM is armed and the RAM page is below ram_bank_count.
- R11: Writes to 0x6000–0xFFFF change none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| rom_bank_count | input | 10 | Number of 16 KiB ROM pages fitted |
| ram_bank_count | input | 5 | Number of 8 KiB RAM pages fitted, 0 when no RAM |
| rom_addr | output | 23 | Physical ROM byte address |
| ram_addr | output | 17 | Physical RAM byte address |
| ram_we | output | 1 | RAM write enable |
| zero_data | output | 1 | Current read must return zero |

## Verification
A corrupted register shows up on the very next access to the window it maps. A wrong ROM page bit moves rom_addr in the 0x4000 window by a multiple of 0x4000, and it can also flip zero_data near the page count. A wrong RAM page or arm bit moves ram_addr, or wrongly blocks or allows ram_we and zero_data, on the next RAM window access. Because every write in the sweeps is followed within two cycles by a read of the affected window, a wrong bit is seen no more than a couple of cycles after the write that caused it.

// File: rtl/rom9_bank_ctrl.sv
module rom9_bank_ctrl #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int ROM_PAGE_W = 14,
  parameter int RAM_PAGE_W = 13,
  parameter logic [7:0] ARM_KEY = 8'h0A
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [15:0]                      cpu_addr,
  input  logic [7:0]                       cpu_wdata,
  input  logic                             cpu_rd,
  input  logic                             cpu_wr,
  input  logic [ROM_BANK_W:0]              rom_bank_count,
  input  logic [RAM_BANK_W:0]              ram_bank_count,
  output logic [ROM_BANK_W+ROM_PAGE_W-1:0] rom_addr,
  output logic [RAM_BANK_W+RAM_PAGE_W-1:0] ram_addr,
  output logic                             ram_we,
  output logic                             zero_data
);
  localparam int HI_W = ROM_BANK_W - 8;

  logic [ROM_BANK_W-1:0] rom_pg_q;
  logic [RAM_BANK_W-1:0] ram_pg_q;
  logic                  armed_q;

  wire hit_arm  = cpu_addr[15:13] == 3'b000;
  wire hit_lo   = cpu_addr[15:12] == 4'h2;
  wire hit_hi   = cpu_addr[15:12] == 4'h3;
  wire hit_rsel = cpu_addr[15:13] == 3'b010;
  wire hit_swin = cpu_addr[15:14] == 2'b01;
  wire hit_ram  = cpu_addr[15:13] == 3'b101;

  wire ram_fitted = ram_bank_count != '0;
  wire rom_ok     = {1'b0, rom_pg_q} < rom_bank_count;
  wire ram_ok     = armed_q && ({1'b0, ram_pg_q} < ram_bank_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_pg_q <= ROM_BANK_W'(1);
      ram_pg_q <= '0;
      armed_q  <= 1'b0;
    end else if (cpu_wr) begin
      if (hit_arm)  armed_q <= (cpu_wdata == ARM_KEY);
      if (hit_lo)   rom_pg_q[7:0] <= cpu_wdata;
      if (hit_hi)   rom_pg_q[ROM_BANK_W-1:8] <= cpu_wdata[HI_W-1:0];
      if (hit_rsel && ram_fitted) ram_pg_q <= cpu_wdata[RAM_BANK_W-1:0];
    end
  end

  assign rom_addr  = {(hit_swin ? rom_pg_q : {ROM_BANK_W{1'b0}}), cpu_addr[ROM_PAGE_W-1:0]};
  assign ram_addr  = {ram_pg_q, cpu_addr[RAM_PAGE_W-1:0]};
  assign ram_we    = cpu_wr && hit_ram && ram_ok;
  assign zero_data = cpu_rd && ((hit_swin && !rom_ok) || (hit_ram && !ram_ok));

  // R2
  lo_write_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr >= 16'h2000 && cpu_addr < 16'h3000) |=>
      (rom_pg_q[ROM_BANK_W-1:8] == $past(rom_pg_q[ROM_BANK_W-1:8])) && (rom_pg_q[7:0] == $past(cpu_wdata)));

  // R3
  hi_write_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr >= 16'h3000 && cpu_addr < 16'h4000) |=> $stable(rom_pg_q[7:0]));

  // R8
  absent_ram_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr >= 16'h4000 && cpu_addr < 16'h6000 && ram_bank_count == '0) |=> $stable(ram_pg_q));

  // R10
  ram_we_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_addr >= 16'hA000 && cpu_addr < 16'hC000 &&
                (32'(ram_addr) >> RAM_PAGE_W) < 32'(ram_bank_count)));

  // R11
  upper_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr >= 16'h6000) |=> ($stable(rom_pg_q) && $stable(ram_pg_q) && $stable(armed_q)));

  // R6
  zero_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_data |-> cpu_rd);
endmodule

// File: tb/rom9_bank_ctrl_tb.sv
module rom9_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [9:0]  rom_bank_count = 10'd300;
  logic [4:0]  ram_bank_count = 5'd4;
  logic [22:0] rom_addr;
  logic [16:0] ram_addr;
  logic        ram_we;
  logic        zero_data;

  int checks = 0;
  int errors = 0;
  int eb = 1;
  int erb = 0;
  bit een = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rom9_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_bank_count(rom_bank_count),
    .ram_bank_count(ram_bank_count), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .ram_we(ram_we), .zero_data(zero_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_rom(input logic [15:0] a, input string tag);
    int ea;
    bit ez;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    if (a < 16'h4000) begin ea = int'(a); ez = 0; end
    else begin ea = eb * 16384 + (int'(a) - 16384); ez = (eb >= int'(rom_bank_count)); end
    chk(tag, 32'(rom_addr), 32'(ea));
    chk(tag, 32'(zero_data), 32'(ez));
    cpu_rd = 1'b0;
  endtask

  task automatic rd_ram(input logic [15:0] a, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    chk(tag, 32'(ram_addr), 32'(erb * 8192 + (int'(a) - 40960)));
    chk(tag, 32'(zero_data), 32'(!(een && erb < int'(ram_bank_count))));
    cpu_rd = 1'b0;
  endtask

  task automatic wr_ram(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    chk(tag, 32'(ram_we), 32'(een && erb < int'(ram_bank_count)));
    chk(tag, 32'(ram_addr), 32'(erb * 8192 + (int'(a) - 40960)));
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_rom(16'h4000, "R1");
    rd_ram(16'hA000, "R1");
    wr_ram(16'hA010, 8'h11, "R1");

    // R5 fixed window
    for (int a = 0; a < 16384; a += 257) rd_rom(16'(a), "R5");
    rd_rom(16'h3FFF, "R5");

    // R2 R3 R6 sweep of all 512 pages, low then high field
    for (int b = 0; b < 512; b++) begin
      wr(16'h2000 | 16'((b * 13) & 12'hFFF), 8'(b & 255));
      eb = (eb & 256) | (b & 255);
      rd_rom(16'h4000 | 16'((b * 37) & 16'h3FFF), "R2");
      wr(16'h3000 | 16'((b * 7) & 12'hFFF), 8'hA4 | 8'(b >> 8));
      eb = b;
      rd_rom(16'h4000 | 16'((b * 101) & 16'h3FFF), "R3");
    end

    // R6 boundary around page count 300
    wr(16'h3000, 8'h01); wr(16'h2000, 8'd43); eb = 299; rd_rom(16'h7FFF, "R6");
    wr(16'h2000, 8'd44); eb = 300; rd_rom(16'h4000, "R6");
    @(negedge clk); cpu_addr = 16'h4000; cpu_rd = 1'b0; #1;
    chk("R6", 32'(zero_data), 32'd0);

    // R4 page zero is not remapped
    wr(16'h3FFF, 8'h00); wr(16'h2FFF, 8'h00); eb = 0;
    rd_rom(16'h4000, "R4");
    rd_rom(16'h5234, "R4");

    // R7 arm and disarm
    wr(16'h1FFF, 8'h0A); een = 1; rd_ram(16'hA000, "R7");
    wr(16'h0000, 8'h0B); een = 0; rd_ram(16'hA000, "R7");
    wr_ram(16'hA001, 8'h5A, "R7");
    wr(16'h0800, 8'h0A); een = 1; rd_ram(16'hA002, "R7");

    // R8 R9 R10 all RAM pages, armed and disarmed
    for (int p = 0; p < 16; p++) begin
      wr(16'h4000 | 16'((p * 509) & 16'h1FFF), 8'hF0 | 8'(p));
      erb = p;
      rd_ram(16'hA000 | 16'((p * 293) & 16'h1FFF), "R9");
      wr_ram(16'hBFFF - 16'(p), 8'(p), "R10");
      wr(16'h0000, 8'h00); een = 0;
      rd_ram(16'hB000, "R9");
      wr_ram(16'hA100, 8'(p), "R10");
      wr(16'h0000, 8'h0A); een = 1;
    end

    // R8 no RAM fitted: page write ignored
    wr(16'h4000, 8'h02); erb = 2;
    ram_bank_count = 5'd0;
    wr(16'h5000, 8'h01);
    rd_ram(16'hA123, "R8");
    wr_ram(16'hA123, 8'h00, "R8");
    ram_bank_count = 5'd4;
    rd_ram(16'hA123, "R8");

    // R11 writes above 0x5FFF are inert
    wr(16'h2000, 8'h05); wr(16'h3000, 8'h00); eb = 5;
    for (int a = 16'h6000; a < 32'h10000; a += 16'h0FF1) wr(16'(a), 8'hFF);
    wr_ram(16'hA040, 8'h0A, "R11");
    rd_rom(16'h4321, "R11");
    rd_ram(16'hA040, "R11");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule